// File: doc/BRIEF.md
# Coprocessor interrupt control and status register

This block is a 16-bit control/status register that sits between a host processor and a signal coprocessor. It collects three interrupt sources: the coprocessor itself, completion of the auxiliary-memory DMA engine, and the audio DMA engine. Each source has a status bit and an enable bit. The enable bit is placed in the bit position directly above its status bit, so the combined request is simply `(reg >> 1) & reg` restricted to the three status positions.

Event inputs set status bits. The host clears a status bit by writing 1 to it, and writing 0 to it leaves it unchanged. In the same host write, the host stores the coprocessor control bits (reset, halt, init, assert-interrupt) and the three enable bits. A read-only bit shows whether the auxiliary DMA engine is busy. Writing the reset bit as 1 also sends a one-cycle pulse that clears the audio DMA control register in the neighbouring block. The combined interrupt line is registered.

Top module: `irq_csr`

## Requirements
- R1: Out of reset, `rd_data` reads 0x0004 (halt bit 2 set, all others 0, with `aux_busy` low), and both `irq_out` and `aud_ctl_clr` are 0.
- R2: An event input sets its status bit at the next clock edge: `ev_aud` sets bit 3, `ev_aux` sets bit 5 and `ev_cop` sets bit 7. No write can set these bits.
- R3: A write with 1 in status bit 3, 5 or 7 clears that bit at the clock edge. A write with 0 in that bit leaves it unchanged. If an event and a clearing write reach the same bit in the same cycle, the event wins and the bit is set.
- R4: Control bits 0 (coprocessor reset), 1 (assert-interrupt), 2 (halt), 11 (init) and enable bits 4 (audio), 6 (aux DMA) and 8 (coprocessor) take the written value at the clock edge and hold it until the next write.
- R5: `irq_out` is high when status bit 3, 5 or 7 is set together with the bit directly above it (4, 6 or 8). It changes at the same clock edge as the register contents.
- R6: Bit 9 follows `aux_busy` combinationally, and writes have no effect on it. Bits 10 and 12 to 15 always read 0.
- R7: A write with bit 0 set makes `aud_ctl_clr` high for exactly the one cycle that follows the write edge. Any other cycle leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| ev_cop | input | 1 | Coprocessor interrupt event |
| ev_aux | input | 1 | Auxiliary-memory DMA completion event |
| ev_aud | input | 1 | Audio DMA interrupt event |
| aux_busy | input | 1 | Auxiliary DMA engine busy |
| rd_data | output | 16 | Register read value |
| irq_out | output | 1 | Combined interrupt to the host |
| aud_ctl_clr | output | 1 | One-cycle clear pulse for the audio DMA control register |

## Verification
The hardest case to reach from the ports is a clearing write and a new event that arrive at the same status bit in the same cycle. Here a lost interrupt is easy to miss. Directed steps create this collision for each source. Random stimulus with frequent events and writes that carry random one-hot clears also produces it many times. Random enable patterns check that `irq_out` pairs each status bit only with its own neighbour and never with the enable bit of another source.

// File: rtl/irq_csr.sv
module irq_csr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ev_cop,
  input  logic         ev_aux,
  input  logic         ev_aud,
  input  logic         aux_busy,
  output logic [W-1:0] rd_data,
  output logic         irq_out,
  output logic         aud_ctl_clr
);
  localparam logic [W-1:0] CTRL_MASK = W'(16'h0957);
  localparam logic [W-1:0] STAT_MASK = W'(16'h00A8);
  localparam logic [W-1:0] RST_VAL   = W'(16'h0004);
  localparam int BUSY_POS = 9;

  logic [W-1:0] reg_q, reg_d, ev_vec, clr_vec;
  logic         irq_d;

  assign ev_vec  = W'({ev_cop, 1'b0, ev_aux, 1'b0, ev_aud, 3'b000});
  assign clr_vec = wr_en ? wr_data : '0;

  assign reg_d = ((wr_en ? wr_data : reg_q) & CTRL_MASK)
               | (reg_q & STAT_MASK & ~clr_vec)
               | ev_vec;

  assign irq_d = |((reg_d >> 1) & reg_d & STAT_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q       <= RST_VAL;
      irq_out     <= 1'b0;
      aud_ctl_clr <= 1'b0;
    end else begin
      reg_q       <= reg_d;
      irq_out     <= irq_d;
      aud_ctl_clr <= wr_en & wr_data[0];
    end
  end

  always_comb begin
    rd_data           = reg_q;
    rd_data[BUSY_POS] = aux_busy;
  end
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        ev_cop,
  input logic        ev_aux,
  input logic        ev_aud,
  input logic        aux_busy,
  input logic [15:0] rd_data,
  input logic        irq_out,
  input logic        aud_ctl_clr
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aud |=> rd_data[3]);

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5] && !ev_aux) |=> !rd_data[5]);

  assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && wr_data[7])) |=> rd_data[7]);

  assert_ctrl_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[2] == $past(wr_data[2]) && rd_data[11] == $past(wr_data[11])));

  assert_irq_pairing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |((rd_data >> 1) & rd_data & 16'h00A8));

  assert_busy_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[9] == aux_busy && rd_data[10] == 1'b0 && rd_data[15:12] == 4'h0);

  assert_pulse_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> aud_ctl_clr);

  assert_pulse_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[0]) |=> !aud_ctl_clr);
endmodule

bind irq_csr irq_csr_chk chk_i (.*);

// File: tb/irq_csr_tb_top.sv
`timescale 1ns/1ps
module irq_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ev_cop = 1'b0, ev_aux = 1'b0, ev_aud = 1'b0, aux_busy = 1'b0;
  logic [15:0] rd_data;
  logic        irq_out, aud_ctl_clr;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_reg = 16'h0004;
  logic        m_irq = 1'b0, m_pulse = 1'b0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_csr dut_i (.*);

  function automatic logic [15:0] nxt(logic [15:0] r, logic we, logic [15:0] wd, logic [2:0] ev);
    logic [15:0] c, s;
    c = (we ? wd : r) & 16'h0957;
    s = (r & 16'h00A8 & ~(we ? wd : 16'h0)) | {8'h0, ev[2], 1'b0, ev[1], 1'b0, ev[0], 3'b000};
    return c | s;
  endfunction

  function automatic logic irqf(logic [15:0] r);
    return |((r >> 1) & r & 16'h00A8);
  endfunction

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ev = {cop, aux, aud}
  task automatic step(logic we, logic [15:0] wd, logic [2:0] ev, logic busy, string tag);
    @(negedge clk);
    wr_en = we; wr_data = wd; {ev_cop, ev_aux, ev_aud} = ev; aux_busy = busy;
    @(posedge clk);
    m_pulse = we & wd[0];
    m_reg   = nxt(m_reg, we, wd, ev);
    m_irq   = irqf(m_reg);
    #1;
    chk(rd_data, m_reg | (16'(busy) << 9), {tag, " rd_data"});
    chk(16'(irq_out), 16'(m_irq), {tag, " irq_out"});
    chk(16'(aud_ctl_clr), 16'(m_pulse), {tag, " aud_ctl_clr"});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(rd_data, 16'h0004, "R1 reset rd_data");
    chk(16'(irq_out), 16'h0, "R1 reset irq_out");
    chk(16'(aud_ctl_clr), 16'h0, "R1 reset aud_ctl_clr");

    step(1'b0, 16'h0, 3'b001, 1'b0, "R2 audio event");
    step(1'b0, 16'h0, 3'b010, 1'b0, "R2 aux event");
    step(1'b0, 16'h0, 3'b100, 1'b0, "R2 cop event, R5 masked off");
    step(1'b1, 16'h0150, 3'b000, 1'b0, "R4 enables set, R5 irq high");
    step(1'b1, 16'h0150, 3'b000, 1'b0, "R3 write zero keeps status");
    step(1'b1, 16'h00F8, 3'b000, 1'b0, "R3 clear all status, R5 irq low");
    step(1'b0, 16'h0, 3'b100, 1'b0, "R5 cop irq pairing");
    step(1'b1, 16'h0080, 3'b100, 1'b0, "R3 event beats clear");
    step(1'b1, 16'h0A87, 3'b000, 1'b0, "R4 ctrl bits, R7 pulse");
    step(1'b0, 16'h0, 3'b000, 1'b0, "R7 pulse one cycle");
    step(1'b1, 16'hF600, 3'b000, 1'b1, "R6 busy mirror and ignored bits");
    step(1'b0, 16'h0, 3'b000, 1'b0, "R6 busy low");
    step(1'b1, 16'h0010, 3'b011, 1'b0, "R2 write cannot set, R5 audio pair");
    step(1'b1, 16'h0028, 3'b000, 1'b0, "R3 clear aud aux, R5 only");

    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [15:0] wd;
      we = ($urandom % 3) == 0;
      wd = 16'($urandom);
      if ($urandom % 2 == 0) wd = (wd & 16'hFF57) | (16'h0008 << (2 * ($urandom % 3)));
      step(we, wd, 3'($urandom % 8 & $urandom % 8), 1'($urandom), "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule